// File: doc/BRIEF.md
# Programmable 8-Line Priority Interrupt Controller

This block gathers eight interrupt request lines and presents a single interrupt output to a processor. Each line can be triggered by a rising edge or by a level. The choice is made per line in a trigger-mode register. Pending requests are held in a request register. They are filtered by a mask register and ranked under a rotating priority scheme. The output is raised only when the best unmasked request outranks every line that is already being serviced.

The processor programs the block over a byte-wide strobe interface. A two-bit address selects one of three registers: the command port, the data port and the trigger-mode register. On the command port it writes a four-word initialisation sequence, end-of-interrupt and rotation commands, and read-select or poll commands. When the processor answers the interrupt with the `ack` strobe, the block returns a vector built from the programmed base and the winning line, and marks that line in service. Auto end-of-interrupt and a polled mode without acknowledge are also supported. Outputs are registered. At most one of write, read or acknowledge is acted on per cycle, and write takes precedence over read, which takes precedence over acknowledge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: An edge-mode line sets its request bit only when its input is 1 in a cycle after it was 0. A held-high input does not set the bit again. An acknowledge of that line clears the bit.
- R2: A write to address 2 loads the trigger-mode register under the mask 0xF8, so bits 0 to 2 always read back as 0. A 1 selects level mode. In level mode the request bit follows the input one cycle later, and an acknowledge does not clear it.
- R3: Line L has rank (L - offset) mod 8, and rank 0 is the highest. `int_out` is 1 one cycle after the state in which the best unmasked request has a strictly lower rank than the best in-service line, or in which requests are pending and no line is in service. Otherwise it is 0.
- R4: A data-port write (address 1) outside initialisation loads the mask register. A masked line never raises `int_out`. A data-port read returns the mask.
- R5: On `ack` with a winner, `vec_out` becomes base | line and the in-service bit of that line is set. With no winner, `vec_out` becomes base | 7 and no in-service bit changes.
- R6: In auto-EOI mode an acknowledge leaves the in-service register unchanged. Command 0x80 enables rotation on auto-EOI and command 0x00 disables it. While rotation is enabled, each acknowledge sets offset = (line + 1) mod 8.
- R7: A command write with bit 4 set starts initialisation, and its bit 0 requests a fourth word. The next data write sets the base to data & 0xF8. The third word is accepted and discarded. The fourth word sets auto-EOI from its bit 1.
- R8: Command code 1 (bits 7:5) clears the in-service bit with the best rank. Code 5 does the same and then sets offset = (that line + 1) mod 8. Code 3 clears in-service bit (data & 7). Code 7 does the same and sets offset = ((data & 7) + 1) mod 8.
- R9: Command code 6 makes line (data & 7) the lowest priority by setting offset = ((data & 7) + 1) mod 8.
- R10: A command write with bits 4:3 = 01 and bit 1 set selects the register that command-port reads return: the in-service register if bit 0 is 1, the request register if bit 0 is 0.
- R11: A command write with bits 4:3 = 01 and bit 2 set arms poll mode. The next read of address 0 or 1 returns 0x80 | line and clears that line's request and in-service bits, or returns 0x07 when no winner exists. The read then disarms poll mode.
- R12: Initialisation keeps the request bits of level lines and clears those of edge lines. It also clears the mask, the offset and the read select, and it clears auto-EOI only when bit 0 of the first word is 0.
- R13: `rdata` changes only in the cycle after a read, and `vec_out` changes only in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, synchronous to clk |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | 0 command port, 1 data port, 2 trigger-mode register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after rd_en |
| ack | input | 1 | Interrupt acknowledge strobe |
| vec_out | output | 8 | Registered vector, valid the cycle after ack |
| int_out | output | 1 | Registered interrupt request to the processor |

## Verification
The directed patterns cover several cases. Simultaneous edges on two lines under different offsets separate a fixed-priority resolver from a rotating one. A held edge input against a held level input separates edge capture from level following. In-service lines of equal rank and of better rank check that the output comparison is strict. Constrained random trials then draw a pattern, a mask and a lowest-priority line. They compare `int_out` and the acknowledged vector with a bench function that ranks lines from the offset, and this exposes wrap-around errors in the rank arithmetic.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam logic [1:0] PORT_CMD  = 2'd0;
  localparam logic [1:0] PORT_DATA = 2'd1;
  localparam logic [1:0] PORT_TRIG = 2'd2;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } init_st_t;

  typedef enum logic [2:0] {
    OP_ROTA_OFF = 3'd0,
    OP_NS_EOI   = 3'd1,
    OP_NONE     = 3'd2,
    OP_SP_EOI   = 3'd3,
    OP_ROTA_ON  = 3'd4,
    OP_ROT_NS   = 3'd5,
    OP_SET_LOW  = 3'd6,
    OP_ROT_SP   = 3'd7
  } cmd_op_t;

endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irq_in,
  input  logic [LINES-1:0] level_mode,
  input  logic [LINES-1:0] clr,
  input  logic             reinit,
  output logic [LINES-1:0] irr
);

  logic [LINES-1:0] prev_lvl;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_lvl[i] <= 1'b0;
        irr[i]      <= 1'b0;
      end else begin
        prev_lvl[i] <= reinit ? 1'b0 : irq_in[i];
        if (level_mode[i]) begin
          irr[i] <= irq_in[i];
        end else if (reinit) begin
          irr[i] <= 1'b0;
        end else begin
          irr[i] <= (irr[i] & ~clr[i]) | (irq_in[i] & ~prev_lvl[i]);
        end
      end
    end
  end

endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int LINES = 8,
  parameter int LW    = $clog2(LINES)
) (
  input  logic [LINES-1:0] vec,
  input  logic [LW-1:0]    off,
  output logic             found,
  output logic [LW-1:0]    line,
  output logic [LW-1:0]    rank
);

  logic [LW-1:0] idx;

  always_comb begin
    found = 1'b0;
    line  = '0;
    rank  = '0;
    idx   = '0;
    for (int r = LINES - 1; r >= 0; r--) begin
      idx = off + LW'(r);
      if (vec[idx]) begin
        found = 1'b1;
        line  = idx;
        rank  = LW'(r);
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int               LINES      = 8,
  parameter logic [LINES-1:0] TRIG_WMASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irq_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] rdata,
  input  logic             ack,
  output logic [LINES-1:0] vec_out,
  output logic             int_out
);
  import pic_pkg::*;

  localparam int LW = $clog2(LINES);
  localparam int BW = LINES - LW;

  logic [LINES-1:0] irr, imr_q, isr_q, elcr_q;
  logic [BW-1:0]    base_q;
  logic [LW-1:0]    off_q;
  logic             aeoi_q, rota_q, init4_q, rsel_q, poll_q;
  init_st_t         init_st;

  logic             found_r, found_s, grant;
  logic [LW-1:0]    line_r, rank_r, line_s, rank_s;
  logic [LINES-1:0] clr, win_hot;
  logic             reinit, poll_rd;
  cmd_op_t          op;

  assign win_hot = LINES'(1) << line_r;
  assign reinit  = wr_en && (addr == PORT_CMD) && wdata[4];
  assign poll_rd = !wr_en && rd_en && poll_q && !addr[1];
  assign op      = cmd_op_t'(wdata[LINES-1:LINES-3]);

  pic_req_latch #(.LINES(LINES)) i_latch (
    .clk(clk), .rst(rst), .irq_in(irq_in), .level_mode(elcr_q),
    .clr(clr), .reinit(reinit), .irr(irr)
  );

  pic_prio_pick #(.LINES(LINES), .LW(LW)) i_pick_req (
    .vec(irr & ~imr_q), .off(off_q),
    .found(found_r), .line(line_r), .rank(rank_r)
  );

  pic_prio_pick #(.LINES(LINES), .LW(LW)) i_pick_isr (
    .vec(isr_q), .off(off_q),
    .found(found_s), .line(line_s), .rank(rank_s)
  );

  assign grant = found_r && (!found_s || (rank_r < rank_s));

  always_comb begin
    clr = '0;
    if (poll_rd && grant) begin
      clr = win_hot;
    end else if (!wr_en && !rd_en && ack && grant) begin
      clr = win_hot & ~elcr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q   <= '0;
      isr_q   <= '0;
      elcr_q  <= '0;
      base_q  <= '0;
      off_q   <= '0;
      aeoi_q  <= 1'b0;
      rota_q  <= 1'b0;
      init4_q <= 1'b0;
      rsel_q  <= 1'b0;
      poll_q  <= 1'b0;
      init_st <= ST_RUN;
      rdata   <= '0;
      vec_out <= '0;
      int_out <= 1'b0;
    end else begin
      int_out <= grant;
      if (wr_en) begin
        case (addr)
          PORT_CMD: begin
            if (wdata[4]) begin
              init4_q <= wdata[0];
              init_st <= ST_BASE;
              imr_q   <= '0;
              off_q   <= '0;
              rsel_q  <= 1'b0;
              if (!wdata[0]) aeoi_q <= 1'b0;
            end else if (wdata[3]) begin
              if (wdata[2]) poll_q <= 1'b1;
              if (wdata[1]) rsel_q <= wdata[0];
            end else begin
              case (op)
                OP_ROTA_OFF: rota_q <= 1'b0;
                OP_ROTA_ON:  rota_q <= 1'b1;
                OP_NS_EOI: if (found_s) isr_q[line_s] <= 1'b0;
                OP_ROT_NS: if (found_s) begin
                  isr_q[line_s] <= 1'b0;
                  off_q <= line_s + LW'(1);
                end
                OP_SP_EOI: isr_q[wdata[LW-1:0]] <= 1'b0;
                OP_ROT_SP: begin
                  isr_q[wdata[LW-1:0]] <= 1'b0;
                  off_q <= wdata[LW-1:0] + LW'(1);
                end
                OP_SET_LOW: off_q <= wdata[LW-1:0] + LW'(1);
                default: ;
              endcase
            end
          end
          PORT_DATA: begin
            case (init_st)
              ST_RUN:  imr_q <= wdata;
              ST_BASE: begin
                base_q  <= wdata[LINES-1:LW];
                init_st <= ST_CASC;
              end
              ST_CASC: init_st <= init4_q ? ST_MODE : ST_RUN;
              ST_MODE: begin
                aeoi_q  <= wdata[1];
                init_st <= ST_RUN;
              end
              default: init_st <= ST_RUN;
            endcase
          end
          PORT_TRIG: elcr_q <= wdata & TRIG_WMASK;
          default: ;
        endcase
      end else if (rd_en) begin
        if (poll_rd) begin
          poll_q <= 1'b0;
          if (grant) begin
            rdata <= {1'b1, {(LINES-1-LW){1'b0}}, line_r};
            isr_q[line_r] <= 1'b0;
          end else begin
            rdata <= LINES'(LINES - 1);
          end
        end else begin
          case (addr)
            PORT_CMD:  rdata <= rsel_q ? isr_q : irr;
            PORT_DATA: rdata <= imr_q;
            PORT_TRIG: rdata <= elcr_q;
            default:   rdata <= '0;
          endcase
        end
      end else if (ack) begin
        if (grant) begin
          vec_out <= {base_q, line_r};
          if (aeoi_q) begin
            if (rota_q) off_q <= line_r + LW'(1);
          end else begin
            isr_q[line_r] <= 1'b1;
          end
        end else begin
          vec_out <= {base_q, LW'(LINES - 1)};
        end
      end
    end
  end

endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int LINES = 8,
  parameter int LW    = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic             ack,
  input logic             aeoi,
  input logic [LINES-1:0] isr,
  input logic [LINES-1:0] rdata,
  input logic [LINES-1:0] vec_out,
  input logic [LINES-LW-1:0] base
);

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_vec_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !(ack && !wr_en && !rd_en) |=> $stable(vec_out));

  assert_isr_set_only_ack_R5: assert property (@(posedge clk) disable iff (rst)
    !(ack && !wr_en && !rd_en) |=> ((isr & ~$past(isr)) == '0));

  assert_aeoi_isr_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (ack && !wr_en && !rd_en && aeoi) |=> (isr == $past(isr)));

  assert_vec_base_R7: assert property (@(posedge clk) disable iff (rst)
    (ack && !wr_en && !rd_en) |=> (vec_out[LINES-1:LW] == $past(base)));

endmodule

bind prio_irq_ctrl pic_ctrl_chk #(.LINES(LINES)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .ack(ack),
  .aeoi(aeoi_q), .isr(isr_q), .rdata(rdata), .vec_out(vec_out),
  .base(base_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vec_out;
  logic       int_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack),
    .vec_out(vec_out), .int_out(int_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; v = vec_out;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); irq_in = irq_in | m;
    @(negedge clk); irq_in = irq_in & ~m;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic init_pic(input logic [7:0] base, input logic aeoi);
    wr(2'd0, 8'h11);
    wr(2'd1, base);
    wr(2'd1, 8'h00);
    wr(2'd1, aeoi ? 8'h03 : 8'h01);
  endtask

  function automatic logic [2:0] exp_win(input logic [7:0] pend, input logic [2:0] off);
    for (int r = 0; r < 8; r++) begin
      if (pend[3'(r) + off]) return 3'(r) + off;
    end
    return 3'd7;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R3 reset int_out", {7'd0, int_out}, 8'h00);
    rd(2'd1, got); check("R4 reset mask", got, 8'h00);
    rd(2'd0, got); check("R10 reset request reg", got, 8'h00);

    // T1: init, edge capture, ack, EOI
    wr(2'd0, 8'h10); wr(2'd1, 8'h47); wr(2'd1, 8'h00);
    pulse(8'h08); settle();
    check("R1 edge sets request", {7'd0, int_out}, 8'h01);
    do_ack(got); check("R5/R7 vector base|3", got, 8'h43);
    wr(2'd0, 8'h0B); rd(2'd0, got); check("R10 isr read", got, 8'h08);
    wr(2'd0, 8'h0A); rd(2'd0, got); check("R1 ack clears edge request", got, 8'h00);
    @(negedge clk); irq_in[5] = 1'b1; settle();
    check("R3 lower-ranked request blocked", {7'd0, int_out}, 8'h00);
    wr(2'd0, 8'h20); settle();
    check("R8 non-specific EOI releases", {7'd0, int_out}, 8'h01);
    do_ack(got); check("R5 vector line 5", got, 8'h45);
    wr(2'd0, 8'h65); settle();
    check("R1 held input no retrigger", {7'd0, int_out}, 8'h00);
    wr(2'd0, 8'h0B); rd(2'd0, got); check("R8 specific EOI clears", got, 8'h00);
    @(negedge clk); irq_in[5] = 1'b0;

    // T2: mask
    wr(2'd1, 8'h10); pulse(8'h10); settle();
    check("R4 masked line silent", {7'd0, int_out}, 8'h00);
    rd(2'd1, got); check("R4 mask readback", got, 8'h10);
    wr(2'd1, 8'h00); settle();
    check("R4 unmask raises", {7'd0, int_out}, 8'h01);
    do_ack(got); check("R4 vector line 4", got, 8'h44);
    wr(2'd0, 8'h64);

    // T3: level mode
    wr(2'd2, 8'hFF); rd(2'd2, got); check("R2 trigger mask", got, 8'hF8);
    @(negedge clk); irq_in[6] = 1'b1; settle();
    do_ack(got); check("R2 level vector", got, 8'h46);
    wr(2'd0, 8'h0A); rd(2'd0, got); check("R2 level request kept after ack", got, 8'h40);
    check("R3 equal rank no output", {7'd0, int_out}, 8'h00);
    wr(2'd0, 8'h66); settle();
    check("R2 level re-raises after EOI", {7'd0, int_out}, 8'h01);
    @(negedge clk); irq_in[6] = 1'b0; settle();
    rd(2'd0, got); check("R2 level follows input low", got, 8'h00);
    check("R2 output drops", {7'd0, int_out}, 8'h00);
    wr(2'd2, 8'h00);

    // T4: spurious
    do_ack(got); check("R5 spurious vector", got, 8'h47);
    wr(2'd0, 8'h0B); rd(2'd0, got); check("R5 spurious no isr", got, 8'h00);

    // T5: rotation commands
    wr(2'd0, 8'hC2); pulse(8'h14); settle();
    do_ack(got); check("R9 set-lowest offset", got, 8'h44);
    wr(2'd0, 8'hE4);
    do_ack(got); check("R8 rotate specific EOI", got, 8'h42);
    wr(2'd0, 8'hA0); rd(2'd0, got); check("R8 rotate non-specific clears", got, 8'h00);
    pulse(8'h0A); settle();
    do_ack(got); check("R8 rotate non-specific offset", got, 8'h43);
    wr(2'd0, 8'h63);
    do_ack(got); check("R3 next rank", got, 8'h41);
    wr(2'd0, 8'h61);

    // T6: auto-EOI with rotation
    init_pic(8'h80, 1'b1);
    wr(2'd0, 8'h80); pulse(8'h42); settle();
    do_ack(got); check("R6 auto-EOI vector", got, 8'h81);
    wr(2'd0, 8'h0B); rd(2'd0, got); check("R6 auto-EOI no isr", got, 8'h00);
    do_ack(got); check("R6 second vector", got, 8'h86);
    pulse(8'h81); settle();
    do_ack(got); check("R6 rotated offset favours 7", got, 8'h87);
    do_ack(got); check("R6 offset wraps to 0", got, 8'h80);

    // T7: poll
    pulse(8'h20); settle();
    wr(2'd0, 8'h0C); rd(2'd0, got); check("R11 poll result", got, 8'h85);
    wr(2'd0, 8'h0A); rd(2'd0, got); check("R11 poll clears request", got, 8'h00);
    wr(2'd0, 8'h0C); rd(2'd1, got); check("R11 poll empty", got, 8'h07);
    rd(2'd1, got); check("R11 poll disarmed", got, 8'h00);

    // T8: re-init keeps level requests
    wr(2'd2, 8'hF8);
    @(negedge clk); irq_in[4] = 1'b1;
    pulse(8'h02); settle();
    rd(2'd0, got); check("R12 before init", got, 8'h12);
    wr(2'd1, 8'h01); wr(2'd0, 8'h0B);
    wr(2'd0, 8'h11); wr(2'd1, 8'h40); wr(2'd1, 8'h00);
    rd(2'd0, got); check("R12 edge dropped level kept", got, 8'h10);
    rd(2'd1, got); check("R12 mask cleared", got, 8'h00);
    wr(2'd1, 8'h01);
    @(negedge clk); irq_in[4] = 1'b0;
    wr(2'd2, 8'h00); settle();

    // random trials
    for (int t = 0; t < 40; t++) begin
      logic [7:0] b, m, p;
      logic [2:0] low;
      b   = 8'($urandom) & 8'hF8;
      m   = 8'($urandom);
      p   = 8'($urandom) | 8'h01;
      low = 3'($urandom);
      init_pic(b, 1'b1);
      wr(2'd0, {5'b11000, low});
      wr(2'd1, m);
      pulse(p); settle();
      check("R3 random output", {7'd0, int_out}, {7'd0, |(p & ~m)});
      do_ack(got);
      check("R3/R9 random vector", got, b | {5'd0, exp_win(p & ~m, low + 3'd1)});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule